// File: doc/BRIEF.md
# Double-Buffered PWM Timer Channel

This block generates a pulse-width-modulated waveform from a free-running up-counter. Software sets a period value and an active-width (duty) value through a single-cycle register-write port. The counter never compares against those software registers directly. It uses a shadow copy of each, so a write made in the middle of a cycle cannot cut a pulse short or stretch a period.

The duty write is the commit strobe. Writing the period register on its own changes nothing that can be seen. A duty write arms a reload. At the next counter clear, both shadows take the contents of their software registers together and the arm is released. To change only the period, software writes the new period and then writes the unchanged duty value again. When count enable rises, both shadows are loaded at once and counting starts from zero.

The block has three outputs besides the waveform: a one-cycle pulse on each period match, a one-cycle pulse on each duty match, and a status bit. The status bit records that a software write landed in the same cycle as a reload.

Top module: `pwm_dbuf_timer`

## Requirements
- R1: After reset, with count enable low, pwm_out, irq_period, irq_duty and conflict are all 0.
- R2: While enabled, the counter runs from 0 up to the shadow period P and then clears to 0. One waveform cycle is P+1 clocks, and irq_period is high for exactly one clock of it, the clock in which the count equals P.
- R3: pwm_out is high from the clear until the count equals the shadow duty D, so it is high for min(D, P+1) clocks in each cycle. D = 0 gives a constant low level, and D > P gives a constant high level.
- R4: irq_duty is high for exactly one clock, the clock in which the count equals D. When D > P it never fires.
- R5: A write with wr_sel = 0 updates only the software period register. On its own it never changes the running waveform.
- R6: A write with wr_sel = 1 (the duty register) arms a reload. At the next counter clear, both the period and the duty shadows load from their software registers, and the arm is released.
- R7: A period write followed by a duty write with the unchanged duty value gives a new cycle length and keeps the same high time.
- R8: When cnt_en rises, both shadows load directly from the software registers and the count starts at 0. The first irq_period follows P+1 clocks later.
- R9: While cnt_en is low, the counter is held at 0. pwm_out, irq_period and irq_duty are 0 in the same clock that cnt_en is low, and conflict is cleared.
- R10: A register write in the same clock as an armed reload sets conflict. The bit stays set until cnt_en goes low. Writes made at any other time leave it at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Count enable |
| wr_en | input | 1 | Register write strobe, one clock |
| wr_sel | input | 1 | Write target: 0 = period, 1 = duty (arms reload) |
| wr_data | input | W | Write data |
| pwm_out | output | 1 | PWM waveform |
| irq_period | output | 1 | Period-match pulse |
| irq_duty | output | 1 | Duty-match pulse |
| conflict | output | 1 | Sticky flag: write coincided with reload |

## Verification
The bench writes a period value on its own and then checks that the next two cycles keep the old length. A design that treats every write as a commit would change the length here. It then writes the same duty value again and expects the new length at once. This catches an arm flag that is never set or is sampled one clear late. Duty values of zero and of more than the period test the ends of the compare. A wrong comparison direction or an off-by-one would give a glitch pulse or a one-clock gap. A write placed exactly in the reload clock must raise conflict, and dropping enable must clear it at once and silence the outputs in that same clock. The first cycle after enable must be a full P+1 clocks, so a design that counts before the shadows load is exposed.

// File: rtl/pwm_dbuf_timer.sv
module pwm_dbuf_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  output logic         pwm_out,
  output logic         irq_period,
  output logic         irq_duty,
  output logic         conflict
);
  logic [W-1:0] per_reg, duty_reg, per_buf, duty_buf, cnt;
  logic run, armed;
  logic live, start, reload;

  assign live       = run & cnt_en;
  assign start      = cnt_en & ~run;
  assign irq_period = live & (cnt == per_buf);
  assign irq_duty   = live & (cnt == duty_buf);
  assign pwm_out    = live & (cnt < duty_buf);
  assign reload     = irq_period & armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_reg  <= '0;
      duty_reg <= '0;
    end else if (wr_en) begin
      if (wr_sel) duty_reg <= wr_data;
      else        per_reg  <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;
      cnt <= '0;
    end else begin
      run <= cnt_en;
      if (!cnt_en || start || irq_period) cnt <= '0;
      else                                cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_buf  <= '0;
      duty_buf <= '0;
    end else if (start || reload) begin
      per_buf  <= per_reg;
      duty_buf <= duty_reg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 armed <= 1'b0;
    else if (wr_en && wr_sel)   armed <= 1'b1;
    else if (start || reload)   armed <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 conflict <= 1'b0;
    else if (!cnt_en)           conflict <= 1'b0;
    else if (reload && wr_en)   conflict <= 1'b1;
  end
endmodule

// File: rtl/pwm_dbuf_timer_chk.sv
module pwm_dbuf_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cnt_en,
  input logic         wr_en,
  input logic         wr_sel,
  input logic         pwm_out,
  input logic         irq_period,
  input logic         irq_duty,
  input logic         conflict,
  input logic         run,
  input logic         armed,
  input logic [W-1:0] cnt,
  input logic [W-1:0] per_buf,
  input logic [W-1:0] duty_buf
);
  p_quiet_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |-> (!pwm_out && !irq_period && !irq_duty));

  p_clear_after_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_period |=> (cnt == '0));

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt_en && !irq_period) |=> (cnt == $past(cnt) + 1'b1));

  p_shadow_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt_en && !irq_period) |=> ($stable(per_buf) && $stable(duty_buf)));

  p_arm_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && armed && irq_period && !(wr_en && wr_sel)) |=> !armed);

  p_start_at_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (cnt == '0));

  p_conflict_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && armed && irq_period && wr_en) |=> conflict);

  p_conflict_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> !conflict);
endmodule

bind pwm_dbuf_timer pwm_dbuf_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en), .wr_sel(wr_sel),
  .pwm_out(pwm_out), .irq_period(irq_period), .irq_duty(irq_duty),
  .conflict(conflict), .run(run), .armed(armed), .cnt(cnt),
  .per_buf(per_buf), .duty_buf(duty_buf)
);

// File: tb/pwm_dbuf_timer_bench.sv
`timescale 1ns/1ps
module pwm_dbuf_timer_bench;
  localparam int W = 16;
  logic clk = 0, rst_n = 0, cnt_en = 0, wr_en = 0, wr_sel = 0;
  logic [W-1:0] wr_data = '0;
  logic pwm_out, irq_period, irq_duty, conflict;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  pwm_dbuf_timer #(.W(W)) u_pwm_dbuf_timer (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .pwm_out(pwm_out), .irq_period(irq_period),
    .irq_duty(irq_duty), .conflict(conflict));

  always #4 clk = ~clk;

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(bit sel, int val);
    wr_en = 1; wr_sel = sel; wr_data = W'(val);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic measure(string req, int p, int d);
    int n = 0, hi = 0, dp = 0;
    while (!irq_period) @(negedge clk);
    do begin
      @(negedge clk);
      n++;
      if (pwm_out) hi++;
      if (irq_duty) dp++;
    end while (!irq_period);
    check({req, " cycle length"}, n, p + 1);
    check({req, " high clocks"}, hi, (d < p + 1) ? d : p + 1);
    check({req, " duty pulses"}, dp, (d <= p) ? 1 : 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 pwm_out", pwm_out, 0);
    check("R1 irq_period", irq_period, 0);
    check("R1 irq_duty", irq_duty, 0);
    check("R1 conflict", conflict, 0);
  endtask

  task automatic t_enable(int p, int d);
    int n = 0;
    wr(0, p);
    wr(1, d);
    cnt_en = 1;
    do begin
      @(negedge clk);
      n++;
    end while (!irq_period && n < 100);
    check("R8 first cycle length", n, p + 1);
    measure("R2 R3 R4", p, d);
  endtask

  task automatic t_period_alone();
    @(negedge clk);
    wr(0, 15);
    measure("R5 old period kept", 9, 4);
    measure("R5 old period kept again", 9, 4);
    @(negedge clk);
    wr(1, 4);
    measure("R7 period via duty rewrite", 15, 4);
    check("R10 no conflict on clean writes", conflict, 0);
  endtask

  task automatic t_duty(string req, int p, int d);
    @(negedge clk);
    wr(1, d);
    measure(req, p, d);
  endtask

  task automatic t_both();
    @(negedge clk);
    wr(0, 6);
    wr(1, 3);
    measure("R6 paired reload", 6, 3);
  endtask

  task automatic t_conflict();
    @(negedge clk);
    wr(1, 2);
    while (!irq_period) @(negedge clk);
    wr(1, 5);
    check("R10 conflict set", conflict, 1);
    repeat (3) @(negedge clk);
    check("R10 conflict sticky", conflict, 1);
  endtask

  task automatic t_disable();
    int seen = 0;
    cnt_en = 0;
    #1;
    check("R9 pwm low same clock", pwm_out, 0);
    repeat (6) begin
      @(negedge clk);
      if (pwm_out || irq_period || irq_duty) seen++;
    end
    check("R9 outputs quiet", seen, 0);
    check("R9 conflict cleared", conflict, 0);
    cnt_en = 1;
    measure("R8 re-enable loads shadows", 6, 5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_enable(9, 4);
    t_period_alone();
    t_duty("R6 duty only", 15, 11);
    t_duty("R3 duty zero", 15, 0);
    t_duty("R3 R4 duty over period", 15, 20);
    t_both();
    t_conflict();
    t_disable();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule